// File: doc/BRIEF.md
# Indirect-Register Host Port with Microcode Loader

This block is a byte-wide parallel host port with a two-bit address. A host selects one of four ports per access. The first port sets an index register, and the second port reads or writes the indirect register that the index names. The third port pops bytes from a sliced-data FIFO. The fourth is a status/interrupt register. Indirect writes to a loader index store bytes into a small program RAM. The first such write forces an embedded sequencer into a held reset at program location zero. A write of any value to a release index is the only thing that lets the sequencer run again.

Every indirect data write occupies the port for a fixed number of clocks. While the port is busy, further data writes are dropped. When the busy window ends, a cycle-complete status bit sets. The host can poll that bit, or it can enable it to drive the interrupt line. Status bits stay set until the host writes a 1 to their position. The sequencer fetches code through a separate registered read port on the program RAM.

Top module: `hostport_ucode`

## Requirements
- R1: After synchronous reset, host_rdata, irq and fifo_pop are 0, seq_rst is 1, all status bits and interrupt enables are 0, and the load pointer is at location 0.
- R2: A write with host_addr=00 sets the 8-bit index. A read with host_addr=00 returns the index on host_rdata one cycle after the strobe.
- R3: Indirect data writes (host_addr=01) with index 0x7E store host_wdata at consecutive program RAM locations. Storage restarts at location 0 whenever seq_rst was low before the write. prog_rdata returns mem[prog_raddr] one cycle after prog_raddr is presented.
- R4: A loader write (index 0x7E) sets seq_rst on the next cycle, and seq_rst stays high after the write ends.
- R5: An indirect data write of any value with index 0x7F clears seq_rst on the next cycle.
- R6: An accepted indirect data write keeps the port busy for BUSY_CYCLES clocks. Status bit 0 (cycle complete) sets at the clock edge BUSY_CYCLES cycles after the accepting edge. Any indirect data write made while the port is busy is ignored.
- R7: Writing host_addr=11 clears every status bit whose host_wdata bit is 1. Bits written with 0 are unchanged. Reading host_addr=11 returns the status in bits [1:0] and zeros above.
- R8: Index 0xC1 holds the interrupt enables: bit 0 for cycle complete and bit 1 for FIFO ready. These are written and read through the indirect data port. Reads of other indices return 0.
- R9: irq is high exactly one cycle after (status AND enable) becomes nonzero, and it is low one cycle after that AND becomes zero.
- R10: A read with host_addr=10 while the FIFO is non-empty returns fifo_data and pulses fifo_pop for one cycle. While the FIFO is empty, the read returns 0 and leaves fifo_pop low.
- R11: Status bit 1 (FIFO ready) sets when fifo_empty goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_stb | input | 1 | One-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Port select: 00 index, 01 indirect data, 10 FIFO, 11 status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| irq | output | 1 | Registered host interrupt |
| fifo_empty | input | 1 | Sliced-data FIFO empty flag |
| fifo_data | input | 8 | FIFO head byte |
| fifo_pop | output | 1 | One-cycle FIFO pop |
| seq_rst | output | 1 | Sequencer held reset, program counter to zero |
| prog_raddr | input | PROG_AW | Sequencer fetch address |
| prog_rdata | output | 8 | Registered program RAM byte |

## Verification
The bench goes after the load pointer restart. A design that kept counting across a release would place a fresh load at the old offset instead of location 0. It also sends a second loader byte inside the busy window. A design that accepted that byte would shift every later byte up by one location. The interrupt edge is timed to the exact cycle, so an off-by-one busy counter shows up as irq rising early or late. Other checks cover write-one-to-clear against a write of zeros, and a read of an empty FIFO. A design that popped on an empty read, or returned stale data, would be caught.

// File: rtl/hpu_pkg.sv
package hpu_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX = 2'b00,
    SEL_DATA  = 2'b01,
    SEL_FIFO  = 2'b10,
    SEL_STAT  = 2'b11
  } host_sel_e;

  localparam int NSTAT       = 2;
  localparam int ST_CC       = 0;
  localparam int ST_FIFO_RDY = 1;
endpackage

// File: rtl/hpu_progmem.sv
module hpu_progmem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ucode,
  input  logic          wr_release,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          seq_rst
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] waddr;

  assign waddr = seq_rst ? wptr : '0;

  always_ff @(posedge clk) begin
    if (wr_ucode) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      seq_rst <= 1'b1;
    end else if (wr_ucode) begin
      wptr    <= (waddr == LAST) ? '0 : waddr + 1'b1;
      seq_rst <= 1'b1;
    end else if (wr_release) begin
      seq_rst <= 1'b0;
    end
  end

  assert_hold_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    wr_ucode |=> seq_rst);
  assert_release_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_release && !wr_ucode) |=> !seq_rst);
  assert_ptr_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ucode && !seq_rst) |=> (wptr == AW'(1)));
endmodule

// File: rtl/hpu_status.sv
module hpu_status #(
  parameter int BUSY_CYCLES = 4,
  parameter int NSTAT       = hpu_pkg::NSTAT,
  parameter int CW          = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_acc,
  input  logic             w1c_en,
  input  logic [NSTAT-1:0] w1c_mask,
  input  logic             ien_we,
  input  logic [NSTAT-1:0] ien_wdata,
  input  logic             fifo_empty,
  output logic             busy,
  output logic [NSTAT-1:0] status,
  output logic [NSTAT-1:0] ien,
  output logic             irq
);
  import hpu_pkg::*;

  logic [CW-1:0]    cnt;
  logic             fe_q;
  logic [NSTAT-1:0] set_vec;
  logic [NSTAT-1:0] clr_vec;

  assign busy = (cnt != '0);

  always_comb begin
    set_vec              = '0;
    set_vec[ST_CC]       = (cnt == CW'(1));
    set_vec[ST_FIFO_RDY] = fe_q && !fifo_empty;
    clr_vec              = w1c_en ? w1c_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fe_q   <= 1'b1;
      status <= '0;
      ien    <= '0;
      irq    <= 1'b0;
    end else begin
      if (data_acc)  cnt <= CW'(BUSY_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
      fe_q   <= fifo_empty;
      status <= (status & ~clr_vec) | set_vec;
      if (ien_we) ien <= ien_wdata;
      irq    <= |(status & ien);
    end
  end

  assert_cc_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1)) |=> status[ST_CC]);
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (w1c_en && w1c_mask[ST_CC] && cnt != CW'(1)) |=> !status[ST_CC]);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (|(status & ien)) |=> irq);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !data_acc);
endmodule

// File: rtl/hostport_ucode.sv
module hostport_ucode #(
  parameter int          PROG_DEPTH  = 64,
  parameter int          PROG_AW     = $clog2(PROG_DEPTH),
  parameter int          BUSY_CYCLES = 4,
  parameter logic [7:0]  IDX_UCODE   = 8'h7E,
  parameter logic [7:0]  IDX_RELEASE = 8'h7F,
  parameter logic [7:0]  IDX_IEN     = 8'hC1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_stb,
  input  logic               host_we,
  input  logic [1:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               irq,
  input  logic               fifo_empty,
  input  logic [7:0]         fifo_data,
  output logic               fifo_pop,
  output logic               seq_rst,
  input  logic [PROG_AW-1:0] prog_raddr,
  output logic [7:0]         prog_rdata
);
  import hpu_pkg::*;

  localparam int PAD = 8 - NSTAT;

  host_sel_e        sel;
  logic [7:0]       idx;
  logic             busy;
  logic             wr_any, rd_any, data_acc;
  logic [NSTAT-1:0] status, ien;

  assign sel      = host_sel_e'(host_addr);
  assign wr_any   = host_stb && host_we;
  assign rd_any   = host_stb && !host_we;
  assign data_acc = wr_any && (sel == SEL_DATA) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      host_rdata <= '0;
      fifo_pop   <= 1'b0;
    end else begin
      fifo_pop <= 1'b0;
      if (wr_any && sel == SEL_INDEX) idx <= host_wdata;
      if (rd_any) begin
        case (sel)
          SEL_INDEX: host_rdata <= idx;
          SEL_DATA:  host_rdata <= (idx == IDX_IEN) ? {{PAD{1'b0}}, ien} : 8'h00;
          SEL_FIFO: begin
            host_rdata <= fifo_empty ? 8'h00 : fifo_data;
            fifo_pop   <= !fifo_empty;
          end
          default:   host_rdata <= {{PAD{1'b0}}, status};
        endcase
      end
    end
  end

  hpu_progmem #(.DEPTH(PROG_DEPTH), .AW(PROG_AW)) u_prog (
    .clk       (clk),
    .rst       (rst),
    .wr_ucode  (data_acc && idx == IDX_UCODE),
    .wr_release(data_acc && idx == IDX_RELEASE),
    .wdata     (host_wdata),
    .rd_addr   (prog_raddr),
    .rd_data   (prog_rdata),
    .seq_rst   (seq_rst)
  );

  hpu_status #(.BUSY_CYCLES(BUSY_CYCLES), .NSTAT(NSTAT)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .data_acc  (data_acc),
    .w1c_en    (wr_any && sel == SEL_STAT),
    .w1c_mask  (host_wdata[NSTAT-1:0]),
    .ien_we    (data_acc && idx == IDX_IEN),
    .ien_wdata (host_wdata[NSTAT-1:0]),
    .fifo_empty(fifo_empty),
    .busy      (busy),
    .status    (status),
    .ien       (ien),
    .irq       (irq)
  );

  assert_empty_no_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_any && sel == SEL_FIFO && fifo_empty) |=> (!fifo_pop && host_rdata == 8'h00));
  assert_pop_on_data_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_any && sel == SEL_FIFO && !fifo_empty) |=> fifo_pop);
endmodule

// File: tb/hostport_ucode_tb_top.sv
module hostport_ucode_tb_top;
  localparam int BUSY = 4;
  localparam int AW   = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          host_stb, host_we;
  logic [1:0]    host_addr;
  logic [7:0]    host_wdata, host_rdata;
  logic          irq, fifo_pop, seq_rst;
  logic          fifo_empty;
  logic [7:0]    fifo_data;
  logic [AW-1:0] prog_raddr;
  logic [7:0]    prog_rdata;

  logic [7:0] fq [4];
  int         f_rd = 0, f_wr = 0;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  assign fifo_empty = (f_rd == f_wr);
  assign fifo_data  = fq[f_rd % 4];

  always #4 clk = ~clk;

  hostport_ucode #(.PROG_DEPTH(64), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst(rst), .host_stb(host_stb), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .seq_rst(seq_rst), .prog_raddr(prog_raddr),
    .prog_rdata(prog_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    host_stb = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_stb = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    host_stb = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_stb = 1'b0;
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog_read(input logic [AW-1:0] a, output logic [7:0] d);
    prog_raddr = a;
    @(negedge clk);
    d = prog_rdata;
  endtask

  task automatic t_reset;
    rst = 1'b1; host_stb = 0; host_we = 0; host_addr = 0; host_wdata = 0; prog_raddr = 0;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 rdata", host_rdata, 0);
    check("R1 irq", irq, 0);
    check("R1 pop", fifo_pop, 0);
    check("R1 seq_rst", seq_rst, 1);
    hread(2'b11, rv); check("R1 status", rv, 0);
  endtask

  task automatic t_index;
    hwrite(2'b00, 8'hA5);
    hread(2'b00, rv); check("R2 index readback", rv, 8'hA5);
  endtask

  task automatic t_load_and_busy;
    logic [7:0] d;
    hwrite(2'b00, 8'h7E);
    hwrite(2'b01, 8'h11); idle(BUSY + 1);
    hwrite(2'b01, 8'h22);
    hwrite(2'b01, 8'hEE);           // inside busy window: must be dropped (R6)
    idle(BUSY + 1);
    hwrite(2'b01, 8'h33); idle(BUSY + 1);
    check("R4 seq_rst held", seq_rst, 1);
    prog_read(0, d); check("R3 loc0", d, 8'h11);
    prog_read(1, d); check("R3 loc1", d, 8'h22);
    prog_read(2, d); check("R6 busy write ignored loc2", d, 8'h33);
  endtask

  task automatic t_release_reload;
    logic [7:0] d;
    hwrite(2'b00, 8'h7F);
    hwrite(2'b01, 8'h9C);
    check("R5 release", seq_rst, 0);
    idle(BUSY + 1);
    hwrite(2'b00, 8'h7E);
    hwrite(2'b01, 8'h44);
    check("R4 reload asserts seq_rst", seq_rst, 1);
    idle(BUSY + 1);
    prog_read(0, d); check("R3 restart at 0", d, 8'h44);
    prog_read(1, d); check("R3 loc1 untouched", d, 8'h22);
  endtask

  task automatic t_w1c;
    hread(2'b11, rv); check("R6 cc set", rv & 8'h01, 1);
    hwrite(2'b11, 8'h00);
    hread(2'b11, rv); check("R7 zero write keeps", rv & 8'h01, 1);
    hwrite(2'b11, 8'h03);
    hread(2'b11, rv); check("R7 w1c clears", rv, 0);
  endtask

  task automatic t_irq_timing;
    hwrite(2'b00, 8'hC1);
    hwrite(2'b01, 8'h01); idle(BUSY + 2);
    hread(2'b01, rv); check("R8 ien readback", rv, 8'h01);
    hwrite(2'b11, 8'h03); idle(2);
    check("R9 irq low after clear", irq, 0);
    hwrite(2'b00, 8'h10);
    hread(2'b01, rv); check("R8 other index reads 0", rv, 0);
    hwrite(2'b01, 8'h55);
    idle(BUSY);
    check("R6 irq not yet", irq, 0);
    idle(1);
    check("R9 irq rises", irq, 1);
    hwrite(2'b11, 8'h01); idle(1);
    check("R9 irq falls", irq, 0);
  endtask

  task automatic t_fifo;
    hread(2'b10, rv);
    check("R10 empty read zero", rv, 0);
    check("R10 empty no pop", fifo_pop, 0);
    hwrite(2'b11, 8'h03); idle(1);
    fq[0] = 8'h5A; fq[1] = 8'hC3; f_wr = 2;
    idle(2);
    hread(2'b11, rv); check("R11 fifo ready set", rv & 8'h02, 8'h02);
    for (int i = 0; i < 2; i++) begin
      hread(2'b10, rv);
      check("R10 fifo data", rv, (i == 0) ? 8'h5A : 8'hC3);
      check("R10 pop pulse", fifo_pop, 1);
      if (fifo_pop) f_rd++;
      idle(1);
      check("R10 pop one cycle", fifo_pop, 0);
    end
    hread(2'b10, rv); check("R10 drained read zero", rv, 0);
    check("R10 drained no pop", fifo_pop, 0);
  endtask

  initial begin
    t_reset;
    t_index;
    t_load_and_busy;
    t_release_reload;
    t_w1c;
    t_irq_timing;
    t_fifo;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule